// File: doc/BRIEF.md
# BCD Correction Unit

This unit applies the decimal corrections that a 16-bit accumulator datapath needs after binary arithmetic on BCD data. It takes the accumulator as a high byte and a low byte, together with the incoming auxiliary-carry and carry flags and a 3-bit operation code. It then returns the corrected accumulator and a fresh set of flags. Two operations work on unpacked digits, with one digit per byte and the carry passed into the high byte. Two work on packed digits, with two digits in the low byte. The other two convert between a binary byte and a two-digit unpacked pair by splitting the byte by the radix or folding the pair back into one byte.

The caller pulses `start` while the unit is idle. Five of the operations finish in one cycle. The split operation runs a restoring divide loop of one quotient bit per cycle, and `busy` stays high while it runs. All results are registered and hold until the next operation completes. `done` marks that completion for one cycle.

Top module: `bcd_adjust_unit`

## Requirements
- R1: Op code 0 (unpacked add correction): when AL[3:0] > 9 or the incoming AF is 1, AL is increased by 6, AH by 1 (modulo 256), and AF and CF are both set to 1. Otherwise AF and CF are both cleared. Input AX=000Fh gives 0105h.
- R2: Op code 1 (unpacked subtract correction) uses the same test, but AL is decreased by 6 and AH by 1. Input AX=02FFh gives 0109h.
- R3: After op code 0 or 1, the upper nibble of AL is zero, AF equals CF, and ZF, SF and PF are driven to 0.
- R4: Op code 2 (packed add correction) adds 6 to AL and sets AF when AL[3:0] > 9 or AF=1. It adds 60h and sets CF when AL > 9Fh or CF=1. AH is left unchanged, so AL=0Fh gives 15h.
- R5: Op code 3 (packed subtract correction) uses the same two tests but subtracts 6 and 60h. AL=FFh gives 99h with CF=1.
- R6: In the packed corrections, the high test uses the AL and CF presented at the input, not the value after the low correction. AL=9Ah gives A0h with CF=0, and AL=A0h gives 00h with CF=1.
- R7: Op code 4 (split) sets AH = AL / RADIX and AL = AL mod RADIX, with the old AH ignored. With RADIX=10, AL=0Fh gives AX=0105h and AL=FFh gives AX=1905h.
- R8: Op code 5 (fold) sets AL = (AH*RADIX + AL) mod 256 and AH = 0. AX=0105h gives 000Fh and AX=FFFFh gives 00F5h.
- R9: After op codes 2 to 5, ZF is 1 when the result AL is zero, SF equals AL[7], and PF is 1 when AL holds an even number of ones. Op codes 4 and 5 drive AF and CF to 0.
- R10: For op codes other than 4, `done` is high in the cycle after the `start` cycle. For op code 4, `busy` is high from the cycle after `start` until `done`, which comes 10 cycles after the `start` cycle. `done` lasts one cycle.
- R11: A `start` while `busy` is high is ignored. The outputs hold their previous values until the running split completes, and no extra `done` follows.
- R12: Op codes 6 and 7 return AX, AF and CF unchanged and drive ZF, SF and PF to 0.
- R13: Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code (0 to 7, see requirements) |
| ax_in | input | 16 | Accumulator in: AH in [15:8], AL in [7:0] |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| cf_in | input | 1 | Incoming carry flag |
| ax_out | output | 16 | Corrected accumulator |
| af_out | output | 1 | Resulting auxiliary-carry flag |
| cf_out | output | 1 | Resulting carry flag |
| zf_out | output | 1 | Zero flag of result AL |
| sf_out | output | 1 | Sign flag of result AL |
| pf_out | output | 1 | Even-parity flag of result AL |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Split operation in progress |

## Verification
The bound checker watches the result shape on every `done`. For the unpacked corrections it requires a cleared upper nibble and AF equal to CF. For a fold it requires a zero high byte, and for a split a remainder below the radix. It also checks that ZF, SF and PF agree with the result byte, that each operation completes with its required latency, that the outputs stay frozen while a split runs, and that `busy` never lasts longer than one split. The exact corrected values can only be shown by the bench's scenarios. These include the +6/+60h decisions taken on the original AL and CF, the wrap of AH past FFh, and the quotient and remainder digits. The bench scenarios also cover a start that arrives during a split being dropped, and reset in the middle of a run.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] LO_FIX  = 8'h06;
  localparam logic [BYTE_W-1:0] HI_FIX  = 8'h60;
  localparam logic [3:0]        LO_LIM  = 4'd9;
  localparam logic [BYTE_W-1:0] HI_LIM  = 8'h9F;

  typedef enum logic [2:0] {
    OP_UADD = 3'd0,
    OP_USUB = 3'd1,
    OP_PADD = 3'd2,
    OP_PSUB = 3'd3,
    OP_SPLT = 3'd4,
    OP_FOLD = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } adj_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] ax;
    logic              af;
    logic              cf;
    logic              fl_en;
  } adj_res_t;

endpackage

// File: rtl/bcd_comb_adjust.sv
module bcd_comb_adjust
  import bcd_adj_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  adj_op_e           op_i,
  input  logic [WORD_W-1:0] ax_i,
  input  logic              af_i,
  input  logic              cf_i,
  output adj_res_t          res_o
);

  localparam logic [BYTE_W-1:0] RADIX_B = BYTE_W'(RADIX);

  logic [BYTE_W-1:0] al, ah;
  logic              lo_hit, hi_hit;
  logic [BYTE_W-1:0] lo_step, hi_step;
  logic [BYTE_W-1:0] al_up, al_dn, ah_up, ah_dn;
  logic [BYTE_W-1:0] pk_up, pk_dn, fold;

  assign al = ax_i[BYTE_W-1:0];
  assign ah = ax_i[WORD_W-1:BYTE_W];

  // both tests read the presented AL and flags, before any correction
  assign lo_hit = (al[3:0] > LO_LIM) | af_i;
  assign hi_hit = (al > HI_LIM) | cf_i;

  assign lo_step = lo_hit ? LO_FIX : '0;
  assign hi_step = hi_hit ? HI_FIX : '0;

  assign al_up = al + LO_FIX;
  assign al_dn = al - LO_FIX;
  assign ah_up = ah + 8'd1;
  assign ah_dn = ah - 8'd1;

  assign pk_up = al + lo_step + hi_step;
  assign pk_dn = al - lo_step - hi_step;

  assign fold = ah * RADIX_B + al;

  always_comb begin
    res_o.ax    = ax_i;
    res_o.af    = af_i;
    res_o.cf    = cf_i;
    res_o.fl_en = 1'b0;
    unique case (op_i)
      OP_UADD: begin
        res_o.ax = lo_hit ? {ah_up, 4'h0, al_up[3:0]} : {ah, 4'h0, al[3:0]};
        res_o.af = lo_hit;
        res_o.cf = lo_hit;
      end
      OP_USUB: begin
        res_o.ax = lo_hit ? {ah_dn, 4'h0, al_dn[3:0]} : {ah, 4'h0, al[3:0]};
        res_o.af = lo_hit;
        res_o.cf = lo_hit;
      end
      OP_PADD: begin
        res_o.ax    = {ah, pk_up};
        res_o.af    = lo_hit;
        res_o.cf    = hi_hit;
        res_o.fl_en = 1'b1;
      end
      OP_PSUB: begin
        res_o.ax    = {ah, pk_dn};
        res_o.af    = lo_hit;
        res_o.cf    = hi_hit;
        res_o.fl_en = 1'b1;
      end
      OP_FOLD: begin
        res_o.ax    = {8'h00, fold};
        res_o.af    = 1'b0;
        res_o.cf    = 1'b0;
        res_o.fl_en = 1'b1;
      end
      OP_SPLT: begin
        res_o.af    = 1'b0;
        res_o.cf    = 1'b0;
        res_o.fl_en = 1'b1;
      end
      OP_RSV6, OP_RSV7: begin
        res_o.ax = ax_i;
      end
    endcase
  end

endmodule

// File: rtl/bcd_radix_split.sv
module bcd_radix_split
  import bcd_adj_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] dividend_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [BYTE_W-1:0] quo_o,
  output logic [BYTE_W-1:0] rem_o
);

  localparam int STEPS = BYTE_W;
  localparam int CNT_W = $clog2(STEPS);
  localparam int REM_W = $clog2(RADIX) + 1;
  localparam logic [REM_W-1:0] RAD_R  = REM_W'(RADIX);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(STEPS - 1);

  logic [BYTE_W-1:0] shreg, quo;
  logic [REM_W-1:0]  rem, trial;
  logic [CNT_W-1:0]  cnt;
  logic              fits;

  assign trial = {rem[REM_W-2:0], shreg[BYTE_W-1]};
  assign fits  = (trial >= RAD_R);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      quo    <= '0;
      rem    <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load_i && !busy_o) begin
        shreg  <= dividend_i;
        quo    <= '0;
        rem    <= '0;
        cnt    <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem   <= fits ? (trial - RAD_R) : trial;
        quo   <= {quo[BYTE_W-2:0], fits};
        shreg <= {shreg[BYTE_W-2:0], 1'b0};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST_S) begin
          busy_o <= 1'b0;
          fin_o  <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo;
  assign rem_o = {{(BYTE_W-REM_W){1'b0}}, rem};

endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] val_i,
  input  logic              en_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);

  assign zf_o = en_i & (val_i == '0);
  assign sf_o = en_i & val_i[BYTE_W-1];
  assign pf_o = en_i & ~(^val_i);

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [15:0] ax_in,
  input  logic        af_in,
  input  logic        cf_in,
  output logic [15:0] ax_out,
  output logic        af_out,
  output logic        cf_out,
  output logic        zf_out,
  output logic        sf_out,
  output logic        pf_out,
  output logic        done,
  output logic        busy
);

  adj_op_e           op_e;
  adj_res_t          c_res, n_res;
  logic              accept, split_go;
  logic              sp_busy, sp_fin;
  logic [BYTE_W-1:0] sp_quo, sp_rem;
  logic              n_zf, n_sf, n_pf;
  logic              busy_q;

  assign op_e     = adj_op_e'(op);
  assign accept   = start && !busy_q;
  assign split_go = accept && (op_e == OP_SPLT);

  bcd_comb_adjust #(.RADIX(RADIX)) u_comb (
    .op_i  (op_e),
    .ax_i  (ax_in),
    .af_i  (af_in),
    .cf_i  (cf_in),
    .res_o (c_res)
  );

  bcd_radix_split #(.RADIX(RADIX)) u_split (
    .clk        (clk),
    .rst        (rst),
    .load_i     (split_go),
    .dividend_i (ax_in[BYTE_W-1:0]),
    .busy_o     (sp_busy),
    .fin_o      (sp_fin),
    .quo_o      (sp_quo),
    .rem_o      (sp_rem)
  );

  always_comb begin
    if (sp_fin) begin
      n_res.ax    = {sp_quo, sp_rem};
      n_res.af    = 1'b0;
      n_res.cf    = 1'b0;
      n_res.fl_en = 1'b1;
    end else begin
      n_res = c_res;
    end
  end

  bcd_flag_gen u_flags (
    .val_i (n_res.ax[BYTE_W-1:0]),
    .en_i  (n_res.fl_en),
    .zf_o  (n_zf),
    .sf_o  (n_sf),
    .pf_o  (n_pf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ax_out <= '0;
      af_out <= 1'b0;
      cf_out <= 1'b0;
      zf_out <= 1'b0;
      sf_out <= 1'b0;
      pf_out <= 1'b0;
      done   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sp_fin || (accept && !split_go)) begin
        ax_out <= n_res.ax;
        af_out <= n_res.af;
        cf_out <= n_res.cf;
        zf_out <= n_zf;
        sf_out <= n_sf;
        pf_out <= n_pf;
        done   <= 1'b1;
        busy_q <= 1'b0;
      end else if (split_go) begin
        busy_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q | sp_busy;

endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk #(
  parameter int RADIX = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [2:0]  op,
  input logic [15:0] ax_out,
  input logic        af_out,
  input logic        cf_out,
  input logic        zf_out,
  input logic        sf_out,
  input logic        pf_out,
  input logic        done,
  input logic        busy
);

  logic [2:0] last_op;
  logic [3:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op  <= 3'd0;
      busy_cnt <= 4'd0;
    end else begin
      if (start && !busy) last_op <= op;
      busy_cnt <= busy ? busy_cnt + 4'd1 : 4'd0;
    end
  end

  assert_unpacked_form_R3: assert property (@(posedge clk) disable iff (rst)
    (done && (last_op == 3'd0 || last_op == 3'd1)) |->
      (ax_out[7:4] == 4'h0 && af_out == cf_out && !zf_out && !sf_out && !pf_out));

  assert_split_range_R7: assert property (@(posedge clk) disable iff (rst)
    (done && last_op == 3'd4) |-> (ax_out[7:0] < 8'(RADIX) && !af_out && !cf_out));

  assert_fold_high_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (done && last_op == 3'd5) |-> (ax_out[15:8] == 8'h00 && !af_out && !cf_out));

  assert_flags_match_R9: assert property (@(posedge clk) disable iff (rst)
    (done && last_op >= 3'd2 && last_op <= 3'd5) |->
      (zf_out == (ax_out[7:0] == 8'h00) && sf_out == ax_out[7] && pf_out == ~(^ax_out[7:0])));

  assert_fast_done_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op != 3'd4) |=> (done && !busy));

  assert_split_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 3'd4) |=> (busy && !done));

  assert_busy_window_R10: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= 4'd9);

  assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done || $stable(ax_out)));

  assert_reserved_flags_R12: assert property (@(posedge clk) disable iff (rst)
    (done && last_op >= 3'd6) |-> (!zf_out && !sf_out && !pf_out));

  assert_reset_clear_R13: assert property (@(posedge clk)
    rst |=> (!done && !busy && ax_out == 16'h0000));

endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk #(.RADIX(RADIX)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op     (op),
  .ax_out (ax_out),
  .af_out (af_out),
  .cf_out (cf_out),
  .zf_out (zf_out),
  .sf_out (sf_out),
  .pf_out (pf_out),
  .done   (done),
  .busy   (busy)
);

// File: tb/bcd_adjust_unit_test.sv
`timescale 1ns/1ps
module bcd_adjust_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] ax_in = 16'h0000;
  logic        af_in = 1'b0;
  logic        cf_in = 1'b0;
  logic [15:0] ax_out;
  logic        af_out, cf_out, zf_out, sf_out, pf_out, done, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bcd_adjust_unit #(.RADIX(10)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .ax_in(ax_in),
    .af_in(af_in), .cf_in(cf_in), .ax_out(ax_out), .af_out(af_out),
    .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out), .pf_out(pf_out),
    .done(done), .busy(busy)
  );

  // {op, ax_in, af_in, cf_in, exp_ax, exp {af,cf,zf,sf,pf}}
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {3'd0, 16'h000F, 1'b0, 1'b0, 16'h0105, 5'b11000},  // R1
    {3'd1, 16'h02FF, 1'b0, 1'b0, 16'h0109, 5'b11000},  // R2
    {3'd0, 16'h0034, 1'b0, 1'b0, 16'h0004, 5'b00000},  // R1 no hit
    {3'd0, 16'h0134, 1'b1, 1'b0, 16'h020A, 5'b11000},  // R1 AF forces
    {3'd1, 16'h0500, 1'b1, 1'b0, 16'h040A, 5'b11000},  // R2 AF forces
    {3'd0, 16'hFF09, 1'b1, 1'b0, 16'h000F, 5'b11000},  // R1 AH wraps
    {3'd2, 16'h120F, 1'b0, 1'b0, 16'h1215, 5'b10000},  // R4
    {3'd3, 16'h00FF, 1'b0, 1'b0, 16'h0099, 5'b11011},  // R5
    {3'd2, 16'h009A, 1'b0, 1'b0, 16'h00A0, 5'b10011},  // R6
    {3'd2, 16'h00A0, 1'b0, 1'b0, 16'h0000, 5'b01101},  // R6
    {3'd2, 16'h0005, 1'b0, 1'b1, 16'h0065, 5'b01001},  // R4 CF forces
    {3'd3, 16'h0045, 1'b1, 1'b0, 16'h003F, 5'b10001},  // R5 AF forces
    {3'd2, 16'h009F, 1'b0, 1'b0, 16'h00A5, 5'b10011},  // R6 boundary 9F
    {3'd4, 16'h000F, 1'b1, 1'b1, 16'h0105, 5'b00001},  // R7
    {3'd4, 16'h00FF, 1'b1, 1'b1, 16'h1905, 5'b00001},  // R7
    {3'd4, 16'hAB00, 1'b0, 1'b0, 16'h0000, 5'b00101},  // R7 AH ignored
    {3'd4, 16'h0009, 1'b0, 1'b0, 16'h0009, 5'b00001},  // R7
    {3'd4, 16'h0064, 1'b0, 1'b0, 16'h0A00, 5'b00101},  // R7
    {3'd5, 16'h0105, 1'b1, 1'b1, 16'h000F, 5'b00001},  // R8
    {3'd5, 16'hFFFF, 1'b0, 1'b0, 16'h00F5, 5'b00011},  // R8 wraps
    {3'd5, 16'h0909, 1'b0, 1'b0, 16'h0063, 5'b00001},  // R8
    {3'd5, 16'h0000, 1'b0, 1'b0, 16'h0000, 5'b00101},  // R8 R9 zero
    {3'd6, 16'h1234, 1'b1, 1'b0, 16'h1234, 5'b10000},  // R12
    {3'd7, 16'hABCD, 1'b0, 1'b1, 16'hABCD, 5'b01000}   // R12
  };

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [15:0] a,
                        input logic f_a, input logic f_c, output int lat);
    @(negedge clk);
    op = o; ax_in = a; af_in = f_a; cf_in = f_c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lat;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(ax_out == 16'h0 && !af_out && !cf_out && !zf_out && !sf_out && !pf_out
          && !done && !busy, "R13", "reset outputs",
          {ax_out, 9'b0, af_out, cf_out, zf_out, sf_out, pf_out, done, busy}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  vo;
      logic [15:0] va, ea;
      logic [4:0]  ef;
      int          elat;
      vo = VEC[i][41:39];
      va = VEC[i][38:23];
      ea = VEC[i][20:5];
      ef = VEC[i][4:0];
      elat = (vo == 3'd4) ? 10 : 1;
      run_op(vo, va, VEC[i][22], VEC[i][21], lat);
      check(ax_out == ea, tag_of(vo), "ax_out", {16'h0, ax_out}, {16'h0, ea});
      // R3 R9 flags
      check({af_out, cf_out, zf_out, sf_out, pf_out} == ef,
            (vo <= 3'd1) ? "R3" : (vo >= 3'd6 ? "R12" : "R9"), "flags afczsp",
            {27'h0, af_out, cf_out, zf_out, sf_out, pf_out}, {27'h0, ef});
      check(lat == elat, "R10", "done latency", lat, elat);
      @(negedge clk);
      check(!done, "R10", "done one cycle", {31'h0, done}, 32'h0);
    end

    // R11: start during a split is dropped, outputs held meanwhile
    held = ax_out;
    @(negedge clk);
    op = 3'd4; ax_in = 16'h00FF; af_in = 1'b0; cf_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10", "busy during split", {31'h0, busy}, 32'h1);
    @(negedge clk);
    op = 3'd1; ax_in = 16'h02FF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ax_out == held && !done, "R11", "held while busy", {16'h0, ax_out}, {16'h0, held});
    lat = 3;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 10, "R11", "split latency", lat, 10);
    check(ax_out == 16'h1905, "R11", "split result kept", {16'h0, ax_out}, 32'h1905);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!done && ax_out == 16'h1905, "R11", "no extra done",
            {15'h0, done, ax_out}, 32'h1905);
    end

    // R13 reset mid-run
    @(negedge clk);
    op = 3'd4; ax_in = 16'h0077; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ax_out == 16'h0 && !busy && !done, "R13", "reset mid split",
          {14'h0, busy, done, ax_out}, 32'h0);
    repeat (12) begin
      @(negedge clk);
      check(!done, "R13", "no done after reset", {31'h0, done}, 32'h0);
    end

    summary();
  end

endmodule